// File: doc/BRIEF.md
# RMII receive demultiplexer

This block sits on the MAC side of a reduced media-independent interface. It samples the two-bit receive bus and the combined carrier/data-valid line on the reference clock. From that it recovers a separate carrier-sense flag and an internal receive-data-valid state. While data is valid it packs di-bits into bytes and passes them on with a single-cycle strobe.

The combined line toggles once per nibble after the carrier has gone but buffered data is still draining. The block reads this toggling pattern instead of treating the line as a plain valid signal. Carrier sense therefore drops as soon as the line is low on the first di-bit of a nibble. The frame itself ends only when the line is low on both di-bits of one nibble.

Leading zero di-bits and preamble di-bits are discarded. Byte assembly begins with the di-bit that follows the first `11` di-bit, which closes the start-of-frame delimiter. A speed input selects either a sample on every clock (100 Mb/s) or one sample in the middle of each ten-clock hold window (10 Mb/s). A receive-error pulse seen during a frame sets a sticky flag that lasts until the next frame begins.

Top module: `rmii_rx_demux`

## Requirements
- R1: After reset, `rx_byte` is 0 and `rx_byte_vld`, `carrier` and `rx_err` are low.
- R2: While idle, a sample with `crs_dv` high starts a frame: `carrier` goes high on the clock edge that takes the sample.
- R3: Until a `11` di-bit is sampled within a frame, di-bits (`00`, `01`, `10`) are discarded and produce no byte strobe. A frame whose line stays high with no `11` di-bit (false carrier) delivers no bytes while `carrier` stays high.
- R4: After the `11` di-bit, di-bits are packed least significant first: the first fills bits 1:0 and the fourth fills bits 7:6. `rx_byte_vld` pulses for one clock on the edge that takes the fourth di-bit, with the byte on `rx_byte`.
- R5: In a frame, a low `crs_dv` sample on the first di-bit of a nibble clears `carrier` on that edge, and the frame continues.
- R6: The frame ends only after a low sample on the first di-bit of a nibble is followed by a low sample on the second. The di-bits sampled while the line toggles (low on the first di-bit, high on the second) are still assembled into bytes.
- R7: With `speed_100` low, exactly one sample is taken in every ten consecutive clocks, in the middle of the window. A di-bit held for ten clocks therefore yields the same byte stream as at full rate.
- R8: `rx_er` sampled high during a frame sets `rx_err`, which then stays high after the frame ends. `rx_er` while idle has no effect on `rx_err`.
- R9: `rx_err` is cleared by the sample that starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1: 100 Mb/s sampling, 0: 10 Mb/s sampling |
| rxd | input | 2 | Receive di-bit bus |
| crs_dv | input | 1 | Combined carrier sense / receive data valid |
| rx_er | input | 1 | Receive error indication |
| rx_byte | output | 8 | Assembled receive byte |
| rx_byte_vld | output | 1 | One-clock strobe for `rx_byte` |
| carrier | output | 1 | Recovered carrier sense |
| rx_err | output | 1 | Sticky receive-error flag |

## Verification
A byte strobe and an error-flag update can land on the same sampled di-bit, and so can the carrier drop and an error update. Random frames place the single error pulse on any data di-bit, including the fourth di-bit of a byte and di-bits inside the toggling tail. This happens at both speeds. On every such frame the bench compares the full delivered byte sequence with the bytes it sent, checks the flag after the frame ends, and checks that carrier fell on the first low first-phase sample.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int DIBIT_W  = 2;
  localparam int BYTE_W   = 8;
  localparam int DIBITS_PER_BYTE = BYTE_W / DIBIT_W;
  typedef logic [DIBIT_W-1:0] dibit_t;
  typedef logic [BYTE_W-1:0]  rx_byte_t;
  localparam dibit_t SFD_TAIL = 2'b11;
endpackage

// File: rtl/rmii_rx_tick.sv
module rmii_rx_tick #(
  parameter int DIV_SLOW = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_100,
  output logic sample_en
);
  localparam int CNT_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_SLOW - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(DIV_SLOW / 2 - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (speed_100 || cnt_q == CNT_LAST) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sample_en = speed_100 | (cnt_q == CNT_MID);

  // R7: at the slow rate no two samples are adjacent
  a_r7_slow_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_100 && $past(!speed_100) && $past(sample_en)) |-> !sample_en);
endmodule

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic crs_dv,
  input  logic rx_er,
  output logic take,
  output logic frame_start,
  output logic carrier,
  output logic rx_err
);
  logic dv_q, dv_d;
  logic car_q, car_d;
  logic nib_q, nib_d;     // 0: first di-bit of nibble, 1: second
  logic lowf_q, lowf_d;   // line was low on the first di-bit of this nibble
  logic err_q, err_d;

  always_comb begin
    dv_d = dv_q;  car_d = car_q;  nib_d = nib_q;
    lowf_d = lowf_q;  err_d = err_q;
    take = 1'b0;  frame_start = 1'b0;
    if (sample_en) begin
      if (!dv_q) begin
        if (crs_dv) begin
          frame_start = 1'b1;
          take   = 1'b1;
          dv_d   = 1'b1;
          car_d  = 1'b1;
          nib_d  = 1'b1;
          lowf_d = 1'b0;
          err_d  = rx_er;
        end
      end else begin
        err_d = err_q | rx_er;
        if (!nib_q) begin
          take   = 1'b1;
          nib_d  = 1'b1;
          lowf_d = !crs_dv;
          if (!crs_dv) car_d = 1'b0;
        end else begin
          nib_d = 1'b0;
          if (!crs_dv && lowf_q) begin
            dv_d   = 1'b0;
            lowf_d = 1'b0;
          end else begin
            take = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q <= 1'b0;  car_q <= 1'b0;  nib_q <= 1'b0;
      lowf_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      dv_q <= dv_d;  car_q <= car_d;  nib_q <= nib_d;
      lowf_q <= lowf_d;  err_q <= err_d;
    end
  end

  assign carrier = car_q;
  assign rx_err  = err_q;

  // R5: carrier never outlives the frame
  a_r5_carrier_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    car_q |-> dv_q);
  // R2: carrier only rises together with a new frame
  a_r2_carrier_with_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(car_q) |-> $rose(dv_q));
  // R6: a frame ends only on a low second-phase sample
  a_r6_end_second_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dv_q) |-> $past(sample_en && !crs_dv && nib_q));
  // R8: the error flag rises only from a sampled error
  a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(sample_en && rx_er));
endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer
  import rmii_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  logic     frame_start,
  input  dibit_t   dibit,
  output rx_byte_t rx_byte,
  output logic     rx_byte_vld
);
  localparam int PH_W = $clog2(DIBITS_PER_BYTE);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIBITS_PER_BYTE - 1);

  logic            locked_q, locked_d;
  logic [PH_W-1:0] ph_q, ph_d;
  rx_byte_t        sh_q, sh_d;
  rx_byte_t        byte_q, byte_d;
  logic            vld_q, vld_d;
  logic            hunting;

  always_comb begin
    locked_d = locked_q;  ph_d = ph_q;  sh_d = sh_q;
    byte_d = byte_q;  vld_d = 1'b0;
    hunting = frame_start | !locked_q;
    if (take) begin
      if (hunting) begin
        locked_d = (dibit == SFD_TAIL);
        ph_d     = '0;
      end else begin
        sh_d = {dibit, sh_q[BYTE_W-1:DIBIT_W]};
        ph_d = ph_q + 1'b1;
        if (ph_q == PH_LAST) begin
          vld_d  = 1'b1;
          byte_d = sh_d;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;  ph_q <= '0;  sh_q <= '0;
      byte_q <= '0;  vld_q <= 1'b0;
    end else begin
      locked_q <= locked_d;  ph_q <= ph_d;  sh_q <= sh_d;
      byte_q <= byte_d;  vld_q <= vld_d;
    end
  end

  assign rx_byte     = byte_q;
  assign rx_byte_vld = vld_q;

  // R4: a strobe follows an accepted di-bit taken while already locked
  a_r4_strobe_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(take) && $past(locked_q)));
  // R3: no strobe on the edge that takes a frame's first di-bit
  a_r3_no_strobe_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> !vld_q);
endmodule

// File: rtl/rmii_rx_demux.sv
module rmii_rx_demux
  import rmii_rx_pkg::*;
#(
  parameter int DIV_SLOW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic [1:0] rxd,
  input  logic       crs_dv,
  input  logic       rx_er,
  output logic [7:0] rx_byte,
  output logic       rx_byte_vld,
  output logic       carrier,
  output logic       rx_err
);
  logic sample_en, take, frame_start;

  rmii_rx_tick #(.DIV_SLOW(DIV_SLOW)) u_tick (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .sample_en(sample_en)
  );

  rmii_rx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .crs_dv(crs_dv),
    .rx_er(rx_er), .take(take), .frame_start(frame_start),
    .carrier(carrier), .rx_err(rx_err)
  );

  rmii_rx_packer u_packer (
    .clk(clk), .rst_n(rst_n), .take(take), .frame_start(frame_start),
    .dibit(rxd), .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld)
  );
endmodule

// File: tb/rmii_rx_demux_bench.sv
`timescale 1ns/1ps
module rmii_rx_demux_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100 = 1'b1;
  logic [1:0] rxd = 2'b00;
  logic       crs_dv = 1'b0;
  logic       rx_er = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_byte_vld, carrier, rx_err;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  rmii_rx_demux u_rmii_rx_demux (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .rxd(rxd),
    .crs_dv(crs_dv), .rx_er(rx_er), .rx_byte(rx_byte),
    .rx_byte_vld(rx_byte_vld), .carrier(carrier), .rx_err(rx_err)
  );

  always @(negedge clk) if (rx_byte_vld) got_q.push_back(rx_byte);

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // drive one di-bit for one sample window, return at a falling edge
  task automatic put(logic [1:0] d, logic dv, logic er);
    rxd = d; crs_dv = dv; rx_er = er;
    repeat (speed_100 ? 1 : 10) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [1:0] dibit_of(logic [7:0] b, int k);
    return 2'(b >> (2 * k));
  endfunction

  task automatic compare_bytes(string req);
    check(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < got_q.size()) check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  // nz: leading zero di-bits (even), sfd: send 11, ntog: toggling nibbles at tail
  task automatic run_frame(int nz, bit sfd, int nbytes, int ntog, int er_at);
    logic [7:0] data[8];
    bit err_exp = 0;
    int total = nbytes * 4;
    int tog0 = total - ntog * 2;
    for (int i = 0; i < nbytes; i++) data[i] = 8'($urandom);
    for (int i = 0; i < nz; i++) begin
      put(2'b00, 1'b1, 1'b0);
      if (i == 0) begin
        check(carrier == 1'b1, "R2 carrier at start", carrier, 1);
        check(rx_err == 1'b0, "R9 error cleared at start", rx_err, 0);
      end
    end
    for (int i = 0; i < 7; i++) put(2'b01, 1'b1, 1'b0);
    check(got_q.size() == 0, "R3 preamble gives no bytes", got_q.size(), 0);
    check(carrier == 1'b1, "R3 carrier during preamble", carrier, 1);
    if (sfd) put(2'b11, 1'b1, 1'b0);
    for (int j = 0; j < total; j++) begin
      logic dv = (j >= tog0) ? logic'(j % 2) : 1'b1;
      logic er = (j == er_at);
      if (er) err_exp = 1;
      if (j == tog0 && ntog > 0)
        check(carrier == 1'b1, "R5 carrier before toggle", carrier, 1);
      put(dibit_of(data[j / 4], j % 4), dv, er);
      if (j == tog0 && ntog > 0)
        check(carrier == 1'b0, "R5 carrier drop on first phase", carrier, 0);
    end
    if (sfd) for (int i = 0; i < nbytes; i++) exp_q.push_back(data[i]);
    put(2'b00, 1'b0, 1'b0);
    put(2'b00, 1'b0, 1'b0);
    check(carrier == 1'b0, "R6 carrier off after end", carrier, 0);
    check(rx_err == err_exp, "R8 sticky error", rx_err, int'(err_exp));
    put(2'b00, 1'b0, 1'b0);
    compare_bytes(ntog > 0 ? "R6 bytes through toggle" : "R4 byte stream");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1d5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rx_byte == 8'h00, "R1 reset byte", rx_byte, 0);
    check(rx_byte_vld == 1'b0, "R1 reset strobe", rx_byte_vld, 0);
    check(carrier == 1'b0, "R1 reset carrier", carrier, 0);
    check(rx_err == 1'b0, "R1 reset error", rx_err, 0);

    // directed: plain frame, then toggling tail with error, then clean frame
    run_frame(2, 1, 2, 0, -1);
    run_frame(4, 1, 3, 2, 1);
    run_frame(2, 1, 1, 1, -1);     // R9 checked at its first di-bit
    // R8: error while idle is ignored
    for (int i = 0; i < 4; i++) put(2'b00, 1'b0, 1'b1);
    check(rx_err == 1'b0, "R8 idle error ignored", rx_err, 0);
    check(carrier == 1'b0, "R8 idle stays idle", carrier, 0);
    // R3: false carrier, no delimiter
    run_frame(6, 0, 0, 0, -1);
    // error on last di-bit of a byte, inside the toggle
    run_frame(2, 1, 2, 2, 7);

    for (int f = 0; f < 25; f++) begin
      int nb = 1 + int'($urandom % 5);
      int nt = int'($urandom % 4);
      int nz = 2 + 2 * int'($urandom % 4);
      int ea = ($urandom % 3 == 0) ? int'($urandom % (nb * 4)) : -1;
      if (nt > 2 * nb) nt = 2 * nb;
      run_frame(nz, 1, nb, nt, ea);
    end

    // R7: slow rate, each di-bit held for ten clocks
    speed_100 = 1'b0;
    repeat (13) @(negedge clk);
    run_frame(2, 1, 2, 1, 3);
    run_frame(4, 1, 1, 0, -1);
    for (int f = 0; f < 3; f++) begin
      int nb = 1 + int'($urandom % 3);
      run_frame(2, 1, nb, int'($urandom % 3), ($urandom % 2 == 0) ? 2 : -1);
    end
    check(n_cmp > 12, "R7 slow-rate run complete", n_cmp, 13);

    summary();
    $finish;
  end
endmodule